// File: doc/BRIEF.md
# Double-Buffered 4x4 Crosspoint Switch

The block routes a set of single-bit data lanes through a non-blocking crosspoint. It has one selector per output, and each selector can pick any input. One input may feed any number of outputs at once. Every output keeps its selection in two registers. The first is a staging entry, which software-side control logic writes one output at a time. The second is an active entry, which drives the selector.

A write strobe stores an input code into the staging entry of one output, named by an output code. A commit strobe copies every staging entry into its active entry on the same clock edge. A whole new routing can therefore be prepared over many cycles and then switched in at one instant. When both strobes are high in the same cycle, the value being written goes straight through to the active entry of the addressed output in that cycle. The data outputs are registered.

Top module: `xpt_switch`

## Requirements
- R1: While rst_ni is low, data_o is all zero. After reset, both the staging entry and the active entry of output n hold n, so output n carries input n.
- R2: On every clock edge, data_o[n] takes the value of data_i[s], where s is the active entry of output n just before that edge. Several outputs may select the same input.
- R3: Input codes and output codes are plain binary on SEL_W bits. Code k names port k (with 4 ports: 00 is port 0, 01 port 1, 10 port 2, 11 port 3).
- R4: A clock edge with load_i high writes iaddr_i into the staging entry of output oaddr_i only. The other staging entries keep their values, and no edge with load_i low changes any staging entry.
- R5: A staging write without cfg_i leaves every active entry, and so the routing seen on data_o, unchanged.
- R6: A clock edge with cfg_i high copies all staging entries into the active entries together. The active entries hold while cfg_i is low.
- R7: On an edge with both load_i and cfg_i high, the addressed output's active entry takes iaddr_i directly. The other outputs take their staging values.
- R8: An output whose active entry is not changed by a commit keeps passing data_i of its selection on every cycle around the commit, with no cycle dropped or altered.
- R9: Repeated writes to one output before a commit leave only the last written code, and only that code is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Staging write strobe |
| cfg_i | input | 1 | Commit strobe (staging to active) |
| iaddr_i | input | SEL_W | Input code to store |
| oaddr_i | input | SEL_W | Output whose staging entry is written |
| data_i | input | N_PORTS | Input data lanes |
| data_o | output | N_PORTS | Registered output data lanes |

## Verification
A strobe sampled high on an edge is visible in the staging or active entry right after that edge. The new routing first shows on data_o at the following edge, because data_o registers data_i through the active entries that were in place before that edge. So data_o after edge k always reflects data_i at edge k, routed through the selection that held before edge k. The bench keeps a model of both storage levels. Before each edge it computes the expected data_o from the model, then updates the model with that cycle's strobes, and compares one nanosecond after the edge. The stimulus is mostly random, with directed sequences for every code value, repeated writes, simultaneous strobes and commits that leave some outputs untouched.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
  localparam int DEF_PORTS = 4;

  function automatic int sel_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xpt_stage.sv
`timescale 1ns/1ps
module xpt_stage #(
  parameter int N_PORTS = 4,
  parameter int SEL_W   = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [SEL_W-1:0]               waddr_i,
  input  logic [SEL_W-1:0]               wdata_i,
  output logic [N_PORTS-1:0][SEL_W-1:0]  stage_o
);
  for (genvar n = 0; n < N_PORTS; n++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 stage_o[n] <= SEL_W'(n);
      else if (we_i && (waddr_i == SEL_W'(n)))     stage_o[n] <= wdata_i;
    end
  end
endmodule

// File: rtl/xpt_active.sv
`timescale 1ns/1ps
module xpt_active #(
  parameter int N_PORTS = 4,
  parameter int SEL_W   = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_i,
  input  logic                           load_i,
  input  logic [SEL_W-1:0]               oaddr_i,
  input  logic [SEL_W-1:0]               iaddr_i,
  input  logic [N_PORTS-1:0][SEL_W-1:0]  stage_i,
  output logic [N_PORTS-1:0][SEL_W-1:0]  active_o
);
  for (genvar n = 0; n < N_PORTS; n++) begin : g_ent
    logic             hit;
    logic [SEL_W-1:0] nxt;
    // simultaneous strobes: bypass the staging register
    assign hit = load_i && (oaddr_i == SEL_W'(n));
    assign nxt = hit ? iaddr_i : stage_i[n];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    active_o[n] <= SEL_W'(n);
      else if (cfg_i) active_o[n] <= nxt;
    end
  end
endmodule

// File: rtl/xpt_lane.sv
`timescale 1ns/1ps
module xpt_lane #(
  parameter int N_PORTS = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] data_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               data_o
);
  logic pick;
  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < N_PORTS; k++)
      if (sel_i == SEL_W'(k)) pick = data_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= 1'b0;
    else         data_o <= pick;
  end
endmodule

// File: rtl/xpt_switch.sv
`timescale 1ns/1ps
module xpt_switch #(
  parameter int N_PORTS = xpt_pkg::DEF_PORTS,
  parameter int SEL_W   = xpt_pkg::sel_width(N_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               cfg_i,
  input  logic [SEL_W-1:0]   iaddr_i,
  input  logic [SEL_W-1:0]   oaddr_i,
  input  logic [N_PORTS-1:0] data_i,
  output logic [N_PORTS-1:0] data_o
);
  logic [N_PORTS-1:0][SEL_W-1:0] stage_q;
  logic [N_PORTS-1:0][SEL_W-1:0] active_q;

  xpt_stage #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (load_i),
    .waddr_i (oaddr_i),
    .wdata_i (iaddr_i),
    .stage_o (stage_q)
  );

  xpt_active #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_active (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg_i),
    .load_i   (load_i),
    .oaddr_i  (oaddr_i),
    .iaddr_i  (iaddr_i),
    .stage_i  (stage_q),
    .active_o (active_q)
  );

  for (genvar n = 0; n < N_PORTS; n++) begin : g_lane
    xpt_lane #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .data_i (data_i),
      .sel_i  (active_q[n]),
      .data_o (data_o[n])
    );
  end
endmodule

// File: rtl/xpt_switch_chk.sv
`timescale 1ns/1ps
module xpt_switch_chk #(
  parameter int N_PORTS = 4,
  parameter int SEL_W   = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          load_i,
  input logic                          cfg_i,
  input logic [SEL_W-1:0]              iaddr_i,
  input logic [SEL_W-1:0]              oaddr_i,
  input logic [N_PORTS-1:0]            data_i,
  input logic [N_PORTS-1:0]            data_o,
  input logic [N_PORTS-1:0][SEL_W-1:0] stage_q,
  input logic [N_PORTS-1:0][SEL_W-1:0] active_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb
    if (!rst_ni) assert_reset_zero_R1: assert (data_o == '0);

  for (genvar n = 0; n < N_PORTS; n++) begin : g_out
    assert_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> data_o[n] == $past(data_i[active_q[n]]));
  end

  assert_stage_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !load_i |=> $stable(stage_q));

  assert_stage_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && load_i |=> stage_q[$past(oaddr_i)] == $past(iaddr_i));

  assert_active_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !cfg_i |=> $stable(active_q));

  assert_commit_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && cfg_i && !load_i |=> active_q == $past(stage_q));

  assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && cfg_i && load_i |=> active_q[$past(oaddr_i)] == $past(iaddr_i));
endmodule

bind xpt_switch xpt_switch_chk #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .cfg_i    (cfg_i),
  .iaddr_i  (iaddr_i),
  .oaddr_i  (oaddr_i),
  .data_i   (data_i),
  .data_o   (data_o),
  .stage_q  (stage_q),
  .active_q (active_q)
);

// File: tb/xpt_switch_test.sv
`timescale 1ns/1ps
module xpt_switch_test;
  localparam int N = 4;
  localparam int W = 2;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic         cfg_i = 1'b0;
  logic [W-1:0] iaddr_i = '0;
  logic [W-1:0] oaddr_i = '0;
  logic [N-1:0] data_i = '0;
  logic [N-1:0] data_o;

  xpt_switch #(.N_PORTS(N)) uut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] stage_m [N];
  logic [W-1:0] active_m [N];

  function automatic logic [N-1:0] route(logic [N-1:0] d);
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) r[n] = d[active_m[n]];
    return r;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s data_o=%b expected %b", tag, act, exp);
    end
  endtask

  // one clock: drive, predict, update model, sample 1ns after edge
  task automatic step(bit ld, bit cf, logic [W-1:0] ia, logic [W-1:0] oa,
                      logic [N-1:0] d, string tag);
    logic [N-1:0] exp;
    load_i = ld; cfg_i = cf; iaddr_i = ia; oaddr_i = oa; data_i = d;
    exp = route(d);
    if (ld) stage_m[oa] = ia;
    if (cf) for (int n = 0; n < N; n++) active_m[n] = stage_m[n];
    @(posedge clk_i);
    #1;
    check(tag, data_o, exp);
  endtask

  task automatic idle(int k, string tag);
    for (int i = 0; i < k; i++) step(0, 0, '0, '0, W'($urandom) == 0 ? 4'hF : 4'($urandom), tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int n = 0; n < N; n++) begin stage_m[n] = W'(n); active_m[n] = W'(n); end
    data_i = 4'hF;
    repeat (3) @(posedge clk_i);
    #1 check("R1 reset", data_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // identity after reset
    step(0, 0, 0, 0, 4'b1010, "R1 identity");
    step(0, 0, 0, 0, 4'b0110, "R1 identity");

    // R3: each code to each output, fan-out from one input
    for (int i = 0; i < N; i++) begin
      for (int o = 0; o < N; o++) step(1, 0, W'(i), W'(o), 4'(1 << i), "R5 staged only");
      step(0, 1, 0, 0, 4'(1 << i), "R6 commit");
      step(0, 0, 0, 0, 4'(1 << i), "R3 all from one");
      step(0, 0, 0, 0, ~4'(1 << i), "R3 all from one");
    end

    // R4: write one output only, others unchanged after commit
    step(1, 0, 2'd3, 2'd0, 4'b0101, "R4");
    step(1, 0, 2'd1, 2'd2, 4'b1001, "R4");
    step(0, 1, 0, 0, 4'b1100, "R6");
    step(0, 0, 0, 0, 4'b1010, "R4 addressed only");
    step(0, 0, 0, 0, 4'b0011, "R4 addressed only");

    // R9: repeated writes, last wins
    step(1, 0, 2'd0, 2'd1, 4'b0001, "R9");
    step(1, 0, 2'd2, 2'd1, 4'b0010, "R9");
    step(1, 0, 2'd3, 2'd1, 4'b0100, "R9");
    step(0, 1, 0, 0, 4'b1000, "R9");
    step(0, 0, 0, 0, 4'b1000, "R9 last code");
    step(0, 0, 0, 0, 4'b0111, "R9 last code");

    // R7: simultaneous strobes
    step(1, 1, 2'd1, 2'd3, 4'b0010, "R7");
    step(0, 0, 0, 0, 4'b0010, "R7 bypass");
    step(0, 0, 0, 0, 4'b1101, "R7 bypass");

    // R8: commit changing one output, toggle data every cycle
    step(1, 0, 2'd2, 2'd0, 4'b1111, "R8");
    step(0, 0, 0, 0, 4'b0000, "R8");
    step(0, 1, 0, 0, 4'b1111, "R8 around commit");
    step(0, 0, 0, 0, 4'b0000, "R8 around commit");
    step(0, 0, 0, 0, 4'b1111, "R8 around commit");

    // random traffic, R2
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) == 0, ($urandom % 5) == 0, W'($urandom), W'($urandom),
           4'($urandom), "R2 random");
    idle(4, "R2 idle");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule